// File: doc/BRIEF.md
# Crate Controller Self-Test Station Responder

This block is a dataway slave that answers at the station one below the crate controller's control station, so that the controller and its cable link can be exercised with no real module in the crate. Each command is given as one clock of `cmd_strobe` with the station, subaddress, function and write data already decoded. The block answers in the next cycle with registered Q and X flags and read data, which is always zero.

A small set of commands is recognised. A subaddress-0 write answers Q and X. If its data equals the trigger value 5, it also starts a LAM pulse of a fixed number of clocks. A subaddress-1 write loads a 4-bit test counter. A subaddress-0 plain read answers Q and X. A subaddress-1 fast read (function 5) counts the test counter down and reports Q and X only while the counter is non-zero. Every other command is silent and leaves the state alone.

Top module: `selftest_station`

## Requirements
- R1: While `rst` is high, and in the first cycle after it, `rsp_q`, `rsp_x` and `lam_out` are 0. The test counter is cleared to 0 and any running LAM pulse stops.
- R2: A strobe with station = CTRL_STATION-1 (24 by default), subaddress 0 and function 16 sets `rsp_q` = `rsp_x` = 1 in the cycle after the strobe.
- R3: When the command of R2 carries write data equal to 5, `lam_out` is high for exactly LAM_CYCLES (20) consecutive cycles, starting the cycle after the strobe. Any other data leaves `lam_out` low.
- R4: A trigger of R3 that arrives while a pulse is running restarts the pulse, which then stays high for LAM_CYCLES cycles after the new strobe without dropping in between.
- R5: A strobe with subaddress 1 and function 16 at the station loads the low 4 bits of the write data into the test counter and answers Q = X = 1.
- R6: A strobe with subaddress 0 and function 0 at the station answers Q = X = 1.
- R7: A strobe with subaddress 1 and function 5 at the station answers Q = X = 1 if the counter was non-zero before the command, and Q = X = 0 otherwise. The counter then decrements, holding at 0 rather than wrapping.
- R8: Any other combination of subaddress and function, and any strobe addressed to another station, answers Q = X = 0 and changes neither the counter nor the LAM output.
- R9: In a cycle that follows no strobe, `rsp_q` and `rsp_x` are 0. `rsp_rdata` is 0 at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, 100 MHz nominal |
| rst | input | 1 | Synchronous active-high reset |
| cmd_strobe | input | 1 | One-cycle command valid |
| cmd_station | input | 5 | Decoded station number |
| cmd_sub | input | 4 | Decoded subaddress |
| cmd_func | input | 5 | Decoded function code |
| cmd_wdata | input | 24 | Write data |
| rsp_q | output | 1 | Q response, valid the cycle after the strobe |
| rsp_x | output | 1 | X response, valid the cycle after the strobe |
| rsp_rdata | output | 24 | Read data, always zero |
| lam_out | output | 1 | Timed LAM pulse |

## Verification
The bench drains the test counter to zero and then issues two more fast reads. A design that judged Q after the decrement would drop Q one read early, and one that wrapped would answer Q again at 15. A load of 0x3A checks that only the low four bits are kept, by counting exactly ten Q answers. The LAM pulse is timed cycle by cycle, both alone and when retriggered halfway through, which exposes an off-by-one width or a retrigger that is ignored. Reads and writes aimed at other stations or at unlisted function codes are placed between a load and a fast read, so that any hidden change to the counter shows up at the ports.

// File: rtl/stst_pkg.sv
package stst_pkg;
  typedef enum logic [2:0] {
    OP_NONE,
    OP_PING,
    OP_LOAD,
    OP_RD0,
    OP_FAST
  } stst_op_e;
endpackage

// File: rtl/stst_decode.sv
module stst_decode
  import stst_pkg::*;
#(
  parameter int STN_W        = 5,
  parameter int SUB_W        = 4,
  parameter int FN_W         = 5,
  parameter int DATA_W       = 24,
  parameter int CTRL_STATION = 25,
  parameter int MAGIC        = 5
) (
  input  logic              strobe,
  input  logic [STN_W-1:0]  station,
  input  logic [SUB_W-1:0]  sub,
  input  logic [FN_W-1:0]   func,
  input  logic [DATA_W-1:0] wdata,
  output stst_op_e          op,
  output logic              lam_trig
);
  localparam logic [STN_W-1:0]  MY_STN  = STN_W'(CTRL_STATION - 1);
  localparam logic [SUB_W-1:0]  SUB_A0  = '0;
  localparam logic [SUB_W-1:0]  SUB_A1  = SUB_W'(1);
  localparam logic [FN_W-1:0]   FN_RD   = '0;
  localparam logic [FN_W-1:0]   FN_FAST = FN_W'(5);
  localparam logic [FN_W-1:0]   FN_WR   = FN_W'(16);
  localparam logic [DATA_W-1:0] TRIG_V  = DATA_W'(MAGIC);

  logic hit;
  assign hit = strobe && (station == MY_STN);

  always_comb begin
    op = OP_NONE;
    if (hit) begin
      if (sub == SUB_A0 && func == FN_WR)        op = OP_PING;
      else if (sub == SUB_A1 && func == FN_WR)   op = OP_LOAD;
      else if (sub == SUB_A0 && func == FN_RD)   op = OP_RD0;
      else if (sub == SUB_A1 && func == FN_FAST) op = OP_FAST;
    end
  end

  assign lam_trig = (op == OP_PING) && (wdata == TRIG_V);
endmodule

// File: rtl/stst_counter.sv
module stst_counter #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             dec,
  output logic [CNT_W-1:0] cnt,
  output logic             nz
);
  always_ff @(posedge clk) begin
    if (rst)                     cnt <= '0;
    else if (load)               cnt <= load_val;
    else if (dec && cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign nz = (cnt != '0);

  assert_load_value_R5: assert property (@(posedge clk) disable iff (rst)
    load |=> cnt == $past(load_val));
  assert_dec_step_R7: assert property (@(posedge clk) disable iff (rst)
    (dec && !load && cnt != '0) |=> cnt == $past(cnt) - 1'b1);
  assert_dec_floor_R7: assert property (@(posedge clk) disable iff (rst)
    (dec && !load && cnt == '0) |=> cnt == '0);
  assert_idle_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (!dec && !load) |=> $stable(cnt));
endmodule

// File: rtl/stst_lam_timer.sv
module stst_lam_timer #(
  parameter int LAM_CYCLES = 20
) (
  input  logic clk,
  input  logic rst,
  input  logic trig,
  output logic lam
);
  localparam int TW = $clog2(LAM_CYCLES + 1);
  localparam logic [TW-1:0] FULL = TW'(LAM_CYCLES);

  logic [TW-1:0] left;

  always_ff @(posedge clk) begin
    if (rst) begin
      left <= '0;
      lam  <= 1'b0;
    end else begin
      lam <= trig || (left > TW'(1));
      if (trig)              left <= FULL;
      else if (left != '0)   left <= left - 1'b1;
    end
  end

  assert_pulse_start_R3: assert property (@(posedge clk) disable iff (rst)
    trig |=> (lam && left == FULL));
  assert_pulse_end_R3: assert property (@(posedge clk) disable iff (rst)
    (!trig && left == TW'(1)) |=> !lam);
  assert_left_bound_R4: assert property (@(posedge clk) disable iff (rst)
    left <= FULL);
endmodule

// File: rtl/selftest_station.sv
module selftest_station
  import stst_pkg::*;
#(
  parameter int STN_W        = 5,
  parameter int SUB_W        = 4,
  parameter int FN_W         = 5,
  parameter int DATA_W       = 24,
  parameter int CNT_W        = 4,
  parameter int CTRL_STATION = 25,
  parameter int LAM_CYCLES   = 20,
  parameter int MAGIC        = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_strobe,
  input  logic [STN_W-1:0]  cmd_station,
  input  logic [SUB_W-1:0]  cmd_sub,
  input  logic [FN_W-1:0]   cmd_func,
  input  logic [DATA_W-1:0] cmd_wdata,
  output logic              rsp_q,
  output logic              rsp_x,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              lam_out
);
  localparam logic [STN_W-1:0] MY_STN = STN_W'(CTRL_STATION - 1);

  stst_op_e         op;
  logic             lam_trig;
  logic [CNT_W-1:0] tcnt;
  logic             tcnt_nz;

  stst_decode #(
    .STN_W(STN_W), .SUB_W(SUB_W), .FN_W(FN_W), .DATA_W(DATA_W),
    .CTRL_STATION(CTRL_STATION), .MAGIC(MAGIC)
  ) u_decode (
    .strobe  (cmd_strobe),
    .station (cmd_station),
    .sub     (cmd_sub),
    .func    (cmd_func),
    .wdata   (cmd_wdata),
    .op      (op),
    .lam_trig(lam_trig)
  );

  stst_counter #(.CNT_W(CNT_W)) u_counter (
    .clk     (clk),
    .rst     (rst),
    .load    (op == OP_LOAD),
    .load_val(cmd_wdata[CNT_W-1:0]),
    .dec     (op == OP_FAST),
    .cnt     (tcnt),
    .nz      (tcnt_nz)
  );

  stst_lam_timer #(.LAM_CYCLES(LAM_CYCLES)) u_lam (
    .clk (clk),
    .rst (rst),
    .trig(lam_trig),
    .lam (lam_out)
  );

  // Q and X are registered; a fast read is judged on the pre-decrement count.
  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_q <= 1'b0;
      rsp_x <= 1'b0;
    end else begin
      unique case (op)
        OP_PING, OP_LOAD, OP_RD0: begin
          rsp_q <= 1'b1;
          rsp_x <= 1'b1;
        end
        OP_FAST: begin
          rsp_q <= tcnt_nz;
          rsp_x <= tcnt_nz;
        end
        default: begin
          rsp_q <= 1'b0;
          rsp_x <= 1'b0;
        end
      endcase
    end
  end

  // The test station only ever returns zero data.
  assign rsp_rdata = '0;

  assert_quiet_idle_R9: assert property (@(posedge clk) disable iff (rst)
    !cmd_strobe |=> (!rsp_q && !rsp_x));
  assert_foreign_silent_R8: assert property (@(posedge clk) disable iff (rst)
    (cmd_strobe && cmd_station != MY_STN) |=> (!rsp_q && !rsp_x && $stable(tcnt)));
  assert_fast_q_R7: assert property (@(posedge clk) disable iff (rst)
    (cmd_strobe && cmd_station == MY_STN && cmd_sub == SUB_W'(1) && cmd_func == FN_W'(5))
      |=> (rsp_q == ($past(tcnt) != '0)));
  assert_ping_ack_R2: assert property (@(posedge clk) disable iff (rst)
    (cmd_strobe && cmd_station == MY_STN && cmd_sub == '0 && cmd_func == FN_W'(16))
      |=> (rsp_q && rsp_x));
endmodule

// File: tb/selftest_station_tb.sv
module selftest_station_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic        cmd_strobe;
  logic [4:0]  cmd_station;
  logic [3:0]  cmd_sub;
  logic [4:0]  cmd_func;
  logic [23:0] cmd_wdata;
  logic        rsp_q, rsp_x, lam_out;
  logic [23:0] rsp_rdata;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #5 clk = ~clk;

  selftest_station u_dut (
    .clk(clk), .rst(rst), .cmd_strobe(cmd_strobe), .cmd_station(cmd_station),
    .cmd_sub(cmd_sub), .cmd_func(cmd_func), .cmd_wdata(cmd_wdata),
    .rsp_q(rsp_q), .rsp_x(rsp_x), .rsp_rdata(rsp_rdata), .lam_out(lam_out)
  );

  // vector: station, sub, func, wdata, expected {q,x}
  localparam int NV = 17;
  localparam logic [39:0] VEC [NV] = '{
    {5'd24, 4'd0, 5'd16, 24'd7,    2'b11},
    {5'd24, 4'd0, 5'd0,  24'd0,    2'b11},
    {5'd24, 4'd1, 5'd16, 24'd3,    2'b11},
    {5'd24, 4'd1, 5'd5,  24'd0,    2'b11},
    {5'd24, 4'd1, 5'd5,  24'd0,    2'b11},
    {5'd24, 4'd1, 5'd5,  24'd0,    2'b11},
    {5'd24, 4'd1, 5'd5,  24'd0,    2'b00},
    {5'd24, 4'd1, 5'd5,  24'd0,    2'b00},
    {5'd24, 4'd1, 5'd16, 24'd1,    2'b11},
    {5'd23, 4'd1, 5'd5,  24'd0,    2'b00},
    {5'd24, 4'd2, 5'd16, 24'd9,    2'b00},
    {5'd24, 4'd0, 5'd1,  24'd0,    2'b00},
    {5'd24, 4'd1, 5'd0,  24'd0,    2'b00},
    {5'd25, 4'd1, 5'd16, 24'd9,    2'b00},
    {5'd24, 4'd1, 5'd5,  24'd0,    2'b11},
    {5'd24, 4'd1, 5'd5,  24'd0,    2'b00},
    {5'd24, 4'd1, 5'd16, 24'h3A,   2'b11}
  };

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic issue(input logic [4:0] st, input logic [3:0] sb,
                       input logic [4:0] fn, input logic [23:0] d);
    @(negedge clk);
    cmd_strobe = 1'b1; cmd_station = st; cmd_sub = sb; cmd_func = fn; cmd_wdata = d;
    @(negedge clk);
    cmd_strobe = 1'b0;
  endtask

  function automatic string tag_of(input logic [4:0] st, input logic [3:0] sb,
                                   input logic [4:0] fn);
    if (st != 5'd24) return "R8";
    if (sb == 4'd0 && fn == 5'd16) return "R2";
    if (sb == 4'd1 && fn == 5'd16) return "R5";
    if (sb == 4'd0 && fn == 5'd0)  return "R6";
    if (sb == 4'd1 && fn == 5'd5)  return "R7";
    return "R8";
  endfunction

  task automatic finish_up();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_up();
    end
  end

  initial begin
    int hi;
    rst = 1'b1; cmd_strobe = 1'b0; cmd_station = '0; cmd_sub = '0;
    cmd_func = '0; cmd_wdata = '0;
    repeat (3) @(negedge clk);
    check(!rsp_q && !rsp_x && !lam_out, "R1", "outputs in reset",
          {rsp_q, rsp_x, lam_out}, 0);
    rst = 1'b0;
    @(negedge clk);
    check(!rsp_q && !rsp_x, "R9", "idle after reset", {rsp_q, rsp_x}, 0);
    // counter cleared by reset: fast read gets no Q (R1)
    issue(5'd24, 4'd1, 5'd5, 24'd0);
    check(!rsp_q && !rsp_x, "R1", "counter zero after reset", {rsp_q, rsp_x}, 0);

    // vector table
    for (int i = 0; i < NV; i++) begin
      logic [39:0] v;
      v = VEC[i];
      issue(v[39:35], v[34:31], v[30:26], v[25:2]);
      check({rsp_q, rsp_x} == v[1:0], tag_of(v[39:35], v[34:31], v[30:26]),
            $sformatf("vector %0d q/x", i), {rsp_q, rsp_x}, v[1:0]);
      check(rsp_rdata == 24'd0, "R9", $sformatf("vector %0d rdata", i), rsp_rdata, 0);
      check(!lam_out, "R3", $sformatf("vector %0d no lam", i), lam_out, 0);
      @(negedge clk);
      check(!rsp_q && !rsp_x, "R9", $sformatf("vector %0d idle", i), {rsp_q, rsp_x}, 0);
    end

    // R5: 0x3A loaded as 10 -> exactly ten Q answers
    hi = 0;
    for (int k = 0; k < 12; k++) begin
      issue(5'd24, 4'd1, 5'd5, 24'd0);
      if (rsp_q && rsp_x) hi++;
    end
    check(hi == 10, "R5", "low-bit load drain count", hi, 10);

    // R3: single pulse width
    issue(5'd24, 4'd0, 5'd16, 24'd5);
    check(rsp_q && rsp_x, "R2", "magic write q/x", {rsp_q, rsp_x}, 3);
    hi = 0;
    for (int k = 0; k < 30; k++) begin
      if (lam_out) hi++;
      @(negedge clk);
    end
    check(hi == 20, "R3", "lam pulse width", hi, 20);

    // R4: retrigger halfway
    issue(5'd24, 4'd0, 5'd16, 24'd5);
    hi = 0;
    for (int k = 0; k < 10; k++) begin
      if (lam_out) hi++;
      @(negedge clk);
    end
    issue(5'd24, 4'd0, 5'd16, 24'd5);
    check(hi == 10, "R4", "lam high before retrigger", hi, 10);
    hi = 0;
    for (int k = 0; k < 30; k++) begin
      if (lam_out) hi++;
      @(negedge clk);
    end
    check(hi == 20, "R4", "lam width after retrigger", hi, 20);

    // R8: foreign station magic write does nothing
    issue(5'd20, 4'd0, 5'd16, 24'd5);
    check(!lam_out && !rsp_q, "R8", "foreign magic", {lam_out, rsp_q}, 0);

    // R1: reset mid-pulse
    issue(5'd24, 4'd0, 5'd16, 24'd5);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check(!lam_out, "R1", "reset stops lam", lam_out, 0);
    @(negedge clk);
    check(!lam_out, "R1", "lam stays low after reset", lam_out, 0);

    finish_up();
  end
endmodule